// File: doc/BRIEF.md
# I2C Target Register Interface

This block is an I2C target that gives an external bus controller byte-wide access to a 256-byte internal register array. It oversamples the open-drain SCL and SDA lines with the system clock, which must run at least eight times faster than SCL. It finds start and stop conditions and compares the 7-bit address it receives with one of two fixed values, chosen by a strap input. After an address match it serves either a write transfer or a read transfer. In a write, the first byte sets the register pointer and each byte after it is stored. In a read, bytes are sent from the pointer.

The register pointer is kept between transactions. A write that carries only the pointer byte sets the place where the next read starts. A read with no pointer write before it carries on from the byte after the last one accessed. After reset the pointer is 00h. The fabric sees a one-cycle write strobe, with its address and data, for every stored byte, and it can read any register through a combinational read port. The array always accepts a write, so the strobe has no ready and the fabric cannot hold it back. The read port also has no handshake.

Top module: `i2c_target_regs`

## Requirements
- R1: The target acknowledges (holds SDA low in the ninth clock slot) an address byte whose upper 7 bits are 1000111b (0x47) while `addr_sel` is 0, or 1100111b (0x67) while `addr_sel` is 1. The least significant bit of that byte is the direction: 0 means write and 1 means read.
- R2: An address that does not match gets no acknowledge. The bytes that follow it, up to the next start, cause no register write and no SDA drive.
- R3: In a write transfer, the first byte after the address loads the pointer. Each later byte is stored at the pointer, after which the pointer advances by one. Every byte is acknowledged. Each stored byte gives exactly one single-cycle `wr_en` pulse, with `wr_addr` and `wr_data`, raised while SCL is low.
- R4: A write transfer that holds only the pointer byte and then a stop makes the next read start at that pointer.
- R5: A read starts at the pointer. After reset the pointer is 00h. After each byte sent, the pointer advances by one, so the next read goes on from the last byte read plus one.
- R6: Read bytes are sent MSB first. When the controller acknowledges, the next byte follows. When it does not, SDA is released and stays released.
- R7: The pointer is 8 bits wide and wraps from FFh to 00h, for writes as well as reads.
- R8: A start or a stop in the middle of a byte abandons that byte without any write. A stop returns the target to idle, and a start begins a new address phase. SDA is released on either one.
- R9: SDA is only ever pulled low, through `sda_oe`, and `sda_oe` changes only while the sampled SCL is low.
- R10: After reset all registers read 00h, `sda_oe` is 0 and `wr_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_sel | input | 1 | Strap selecting target address 0x67 (1) or 0x47 (0) |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Pull SDA low when 1; released when 0 |
| wr_en | output | 1 | One-cycle strobe per stored data byte |
| wr_addr | output | 8 | Register address of the stored byte |
| wr_data | output | 8 | Value of the stored byte |
| fab_rd_addr | input | 8 | Fabric read address |
| fab_rd_data | output | 8 | Register contents at `fab_rd_addr` (combinational) |

## Verification
A wrong pointer shows up at the ports within a transfer. It appears as the wrong byte on SDA during the next read, or as a `wr_addr` that is off by some amount on the next stored byte. A broken bit counter or a lost byte-complete flag moves the acknowledge slot. The controller model then samples a missing or misplaced acknowledge within one byte time. A stuck state after an aborted byte or a failed address match shows as a missing acknowledge, or an unwanted one, on the very next transaction. The fabric read port then shows whether any stray write reached the array.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam logic [6:0] TGT_ADDR_HI = 7'h67;
  localparam logic [6:0] TGT_ADDR_LO = 7'h47;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } tgt_state_t;

  typedef enum logic [1:0] {
    RX_ADDR,
    RX_SUB,
    RX_DATA
  } rx_kind_t;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  // Flops reset to the idle-bus level so no edge appears after reset
  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[STAGES-2:0], scl_i};
          sda_ff <= {sda_ff[STAGES-2:0], sda_i};
        end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_ff[STAGES-1];
      sda_q <= sda_ff[STAGES-1];
    end

  assign scl_lvl   = scl_ff[STAGES-1];
  assign sda_lvl   = sda_ff[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/i2c_reg_file.sv
module i2c_reg_file #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_sel,
  input  logic          sda_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [DW-1:0] rd_byte,
  output logic [AW-1:0] ptr,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  localparam int BCW = $clog2(DW);

  tgt_state_t    st;
  rx_kind_t      kind;
  logic [BCW-1:0] cnt;
  logic [DW-1:0] rx_sh, tx_sh;
  logic          full, rd_mode, m_ack;
  logic [6:0]    my_addr;

  assign my_addr = addr_sel ? TGT_ADDR_HI : TGT_ADDR_LO;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= ST_IDLE;      kind <= RX_ADDR;  cnt <= '0;
      rx_sh <= '0;        tx_sh <= '0;      full <= 1'b0;
      rd_mode <= 1'b0;    m_ack <= 1'b0;    ptr <= '0;
      sda_oe <= 1'b0;     wr_en <= 1'b0;    wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        st <= ST_RX; kind <= RX_ADDR; cnt <= '0; full <= 1'b0; sda_oe <= 1'b0;
      end else if (stop_det) begin
        st <= ST_IDLE; full <= 1'b0; sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise && !full) begin
              rx_sh <= {rx_sh[DW-2:0], sda_lvl};
              cnt   <= cnt + 1'b1;
              if (cnt == BCW'(DW-1)) full <= 1'b1;
            end else if (scl_fall && full) begin
              full <= 1'b0;
              cnt  <= '0;
              case (kind)
                RX_ADDR:
                  if (rx_sh[DW-1:1] == my_addr) begin
                    sda_oe <= 1'b1; rd_mode <= rx_sh[0]; st <= ST_ACK;
                  end else begin
                    st <= ST_IDLE;
                  end
                RX_SUB: begin
                  ptr <= AW'(rx_sh); sda_oe <= 1'b1; st <= ST_ACK;
                end
                default: begin
                  wr_en <= 1'b1; wr_addr <= ptr; wr_data <= rx_sh;
                  ptr <= ptr + 1'b1; sda_oe <= 1'b1; st <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK:
            if (scl_fall) begin
              if (kind == RX_ADDR && rd_mode) begin
                tx_sh <= rd_byte; sda_oe <= ~rd_byte[DW-1];
                ptr <= ptr + 1'b1; cnt <= '0; st <= ST_TX;
              end else begin
                sda_oe <= 1'b0; st <= ST_RX;
                kind <= (kind == RX_ADDR) ? RX_SUB : RX_DATA;
              end
            end
          ST_TX:
            if (scl_fall) begin
              if (cnt == BCW'(DW-1)) begin
                sda_oe <= 1'b0; cnt <= '0; st <= ST_MACK;
              end else begin
                cnt <= cnt + 1'b1;
                tx_sh <= {tx_sh[DW-2:0], 1'b0};
                sda_oe <= ~tx_sh[DW-2];
              end
            end
          ST_MACK: begin
            if (scl_rise) m_ack <= ~sda_lvl;
            if (scl_fall) begin
              if (m_ack) begin
                tx_sh <= rd_byte; sda_oe <= ~rd_byte[DW-1];
                ptr <= ptr + 1'b1; cnt <= '0; st <= ST_TX;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
endmodule

// File: rtl/i2c_target_regs.sv
module i2c_target_regs #(
  parameter int AW          = 8,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_sel,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  input  logic [AW-1:0] fab_rd_addr,
  output logic [DW-1:0] fab_rd_data
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic [AW-1:0] ptr;
  logic [DW-1:0] ptr_byte;

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  i2c_tgt_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .rd_byte(ptr_byte), .ptr(ptr), .sda_oe(sda_oe),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  i2c_reg_file #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr_a(ptr), .rdata_a(ptr_byte),
    .raddr_b(fab_rd_addr), .rdata_b(fab_rd_data)
  );
endmodule

// File: rtl/i2c_target_regs_chk.sv
module i2c_target_regs_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_lvl,
  input logic start_det,
  input logic stop_det,
  input logic sda_oe,
  input logic wr_en
);
  assert_oe_moves_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_det) && !$past(stop_det)) |-> !scl_lvl);

  assert_strobe_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  assert_strobe_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !scl_lvl);

  assert_stop_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  assert_start_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);

  assert_no_write_on_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |=> !wr_en);
endmodule

bind i2c_target_regs i2c_target_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .start_det(start_det),
  .stop_det(stop_det), .sda_oe(sda_oe), .wr_en(wr_en)
);

// File: tb/sim_i2c_target_regs.sv
module sim_i2c_target_regs;
  localparam int CLK_PERIOD = 10;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0, addr_sel = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, wr_en;
  logic [7:0] wr_addr, wr_data, fab_rd_addr, fab_rd_data;
  wire sda_line = sda_m & ~sda_oe;

  int vectors = 0, miscompares = 0, strobes = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (rst_n && wr_en) strobes <= strobes + 1;

  i2c_target_regs u0 (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fab_rd_addr(fab_rd_addr), .fab_rd_data(fab_rd_data)
  );

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_is(string req, logic [7:0] a, logic [7:0] exp);
    fab_rd_addr = a;
    #1;
    check(req, fab_rd_data, exp);
  endtask

  task automatic bus_start();
    wait_clk(2); sda_m = 1'b1; wait_clk(2);
    scl_m = 1'b1; wait_clk(H);
    sda_m = 1'b0; wait_clk(H);
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wait_clk(2); sda_m = 1'b0; wait_clk(H);
    scl_m = 1'b1; wait_clk(H);
    sda_m = 1'b1; wait_clk(H);
  endtask

  task automatic put_bit(logic b);
    wait_clk(2); sda_m = b; wait_clk(H);
    scl_m = 1'b1; wait_clk(H);
    scl_m = 1'b0;
  endtask

  task automatic put_byte(logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    wait_clk(2); sda_m = 1'b1; wait_clk(H);
    scl_m = 1'b1; wait_clk(H/2);
    ack = ~sda_line;
    wait_clk(H/2); scl_m = 1'b0;
  endtask

  task automatic get_byte(logic give_ack, output logic [7:0] v);
    wait_clk(2); sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_clk(H); scl_m = 1'b1; wait_clk(H/2);
      v[i] = sda_line;
      wait_clk(H/2); scl_m = 1'b0;
    end
    wait_clk(2); sda_m = ~give_ack; wait_clk(H);
    scl_m = 1'b1; wait_clk(H);
    scl_m = 1'b0; wait_clk(2); sda_m = 1'b1;
  endtask

  task automatic t_reset();
    check("R10 sda_oe", sda_oe, 0);
    check("R10 wr_en", wr_en, 0);
    reg_is("R10 reg80", 8'h80, 8'h00);
    reg_is("R10 regFF", 8'hFF, 8'h00);
  endtask

  task automatic t_read_after_reset();
    logic a; logic [7:0] v;
    bus_start(); put_byte({7'h47, 1'b1}, a);
    check("R1 ack read addr 0x47", a, 1);
    get_byte(1'b0, v);
    check("R5 first read from 00h", v, 8'h00);
    bus_stop();
  endtask

  task automatic t_burst_write();
    logic a; int s0 = strobes;
    bus_start(); put_byte({7'h47, 1'b0}, a); check("R1 ack write addr", a, 1);
    put_byte(8'h00, a); check("R3 ack subaddr", a, 1);
    put_byte(8'hA5, a); check("R3 ack data0", a, 1);
    put_byte(8'h3C, a); check("R3 ack data1", a, 1);
    put_byte(8'h5A, a); check("R3 ack data2", a, 1);
    put_byte(8'hC3, a); check("R3 ack data3", a, 1);
    bus_stop();
    check("R3 strobe count", strobes - s0, 4);
    reg_is("R3 reg00", 8'h00, 8'hA5);
    reg_is("R3 reg01", 8'h01, 8'h3C);
    reg_is("R3 reg02", 8'h02, 8'h5A);
    reg_is("R3 reg03", 8'h03, 8'hC3);
  endtask

  task automatic t_pointer_load_and_read();
    logic a; logic [7:0] v; int s0 = strobes;
    bus_start(); put_byte({7'h47, 1'b0}, a); put_byte(8'h01, a); bus_stop();
    check("R4 no strobe on pointer-only write", strobes - s0, 0);
    bus_start(); put_byte({7'h47, 1'b1}, a);
    get_byte(1'b1, v); check("R4 read starts at loaded pointer", v, 8'h3C);
    get_byte(1'b0, v); check("R6 next byte after ack", v, 8'h5A);
    wait_clk(H);
    check("R6 sda released after nack", sda_oe, 0);
    bus_stop();
  endtask

  task automatic t_continue_read();
    logic a; logic [7:0] v;
    bus_start(); put_byte({7'h47, 1'b1}, a);
    get_byte(1'b0, v); check("R5 continues at last read plus one", v, 8'hC3);
    bus_stop();
  endtask

  task automatic t_mismatch();
    logic a; int s0 = strobes;
    bus_start(); put_byte({7'h67, 1'b0}, a);
    check("R2 no ack on wrong address", a, 0);
    put_byte(8'h00, a); check("R2 no ack on later byte", a, 0);
    put_byte(8'hFF, a);
    bus_stop();
    check("R2 no strobe after mismatch", strobes - s0, 0);
    reg_is("R2 reg00 untouched", 8'h00, 8'hA5);
  endtask

  task automatic t_strap_high_wrap();
    logic a; logic [7:0] v;
    addr_sel = 1'b1;
    bus_start(); put_byte({7'h47, 1'b0}, a); bus_stop();
    check("R1 0x47 refused when strap high", a, 0);
    bus_start(); put_byte({7'h67, 1'b0}, a); check("R1 ack 0x67 strap high", a, 1);
    put_byte(8'hFF, a); put_byte(8'hEE, a); put_byte(8'h77, a);
    bus_stop();
    reg_is("R7 regFF", 8'hFF, 8'hEE);
    reg_is("R7 write wrapped to 00", 8'h00, 8'h77);
    bus_start(); put_byte({7'h67, 1'b0}, a); put_byte(8'hFF, a); bus_stop();
    bus_start(); put_byte({7'h67, 1'b1}, a);
    get_byte(1'b1, v); check("R6 msb-first byte FF", v, 8'hEE);
    get_byte(1'b0, v); check("R7 read wrapped to 00", v, 8'h77);
    bus_stop();
  endtask

  task automatic t_abort();
    logic a; int s0 = strobes;
    bus_start(); put_byte({7'h67, 1'b0}, a); put_byte(8'h40, a);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
    bus_stop();
    check("R8 no strobe on aborted byte", strobes - s0, 0);
    reg_is("R8 reg40 untouched", 8'h40, 8'h00);
    check("R8 sda released after stop", sda_oe, 0);
    bus_start(); put_byte({7'h67, 1'b0}, a); put_byte(8'h41, a);
    put_bit(1'b0); put_bit(1'b1);
    bus_start(); put_byte({7'h67, 1'b0}, a);
    check("R8 start mid-byte begins new address", a, 1);
    put_byte(8'h41, a); put_byte(8'h99, a);
    bus_stop();
    reg_is("R8 write after restart", 8'h41, 8'h99);
    check("R8 strobe count after restart", strobes - s0, 1);
  endtask

  initial begin
    wait_clk(200000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    fab_rd_addr = 8'h00;
    wait_clk(4); rst_n = 1'b1; wait_clk(4);
    t_reset();
    t_read_after_reset();
    t_burst_write();
    t_pointer_load_and_read();
    t_continue_read();
    t_mismatch();
    t_strap_high_wrap();
    t_abort();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule